// File: doc/BRIEF.md
# Relocation and limit address unit

This unit sits between a processor's load/store path and the memory system. Each request carries a virtual address, a read/write flag and a valid strobe. A per-process base value is added to the virtual address to form the physical address. The same request is checked against a per-process ceiling on the virtual address. A request that passes produces exactly one physical access one cycle later. A request that fails produces no physical access. Instead it raises an address-error exception, which records the offending virtual address.

The kernel reloads the base and ceiling registers through a small configuration port whenever it switches context. Every process can therefore be built to start at virtual address zero, and each process sees one contiguous physical region.

Top module: `reloc_limit_unit`

## Requirements
- R1: A request accepted with `req_valid` high and no fault gives `mem_valid` high on the next cycle. In that cycle `mem_paddr` = base + `req_vaddr` and `mem_write` = `req_write`.
- R2: A request with `req_vaddr` greater than the ceiling faults and sets bit 0 of `exc_code`. A request with `req_vaddr` equal to the ceiling passes.
- R3: A request whose sum base + `req_vaddr` does not fit in PA_W bits faults and sets bit 1 of `exc_code`. When R2 and R3 both apply, `exc_code` is 2'b11.
- R4: Each non-faulting request gives exactly one `mem_valid` cycle. A cycle without `req_valid` gives no `mem_valid` on the next cycle.
- R5: A faulting request gives no `mem_valid`. On the next cycle `exc_pending` is high.
- R6: A configuration write with `cfg_we` high and `cfg_sel` = 0 loads the base from `cfg_data`. With `cfg_sel` = 1 it loads the ceiling from the low VA_W bits of `cfg_data`. A request in the same cycle as the write still uses the old values; the new values apply from the next request onward.
- R7: A fault captures `req_vaddr`, `req_write` and the cause into `exc_vaddr`, `exc_write` and `exc_code`. These stay unchanged until `exc_ack` is seen, and later faults do not overwrite them. A fault in the same cycle as `exc_ack` is captured as the new exception.
- R8: After reset the base is 0, the ceiling is 0, and `mem_valid` and `exc_pending` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the base register, 1 selects the ceiling register |
| cfg_data | input | PA_W | Configuration write value |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | Request is a write |
| req_vaddr | input | VA_W | Request virtual address |
| mem_valid | output | 1 | Physical access strobe |
| mem_write | output | 1 | Physical access is a write |
| mem_paddr | output | PA_W | Physical address |
| exc_pending | output | 1 | Address-error exception outstanding |
| exc_write | output | 1 | The faulting access was a write |
| exc_code | output | 2 | Fault cause: bit 0 is over the ceiling, bit 1 is physical overflow |
| exc_vaddr | output | VA_W | Faulting virtual address |
| exc_ack | input | 1 | Exception acknowledge |

## Verification
The assertions assume that PA_W is at least VA_W. They also assume that `exc_ack` is raised only by the handler, as a single-cycle pulse, and that the input signals are stable around the clock edge. The bench keeps within these conditions. It drives every input on the falling edge, and it pulses `exc_ack` for one cycle only after it has read an exception. It uses a 4-bit virtual and 5-bit physical configuration. That is small enough to sweep every base, every ceiling and every virtual address, and so it reaches both fault causes and the equal-to-ceiling boundary.

// File: rtl/reloc_limit_unit.sv
module reloc_limit_unit #(
  parameter int VA_W = 16,
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_data,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [VA_W-1:0] req_vaddr,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [PA_W-1:0] mem_paddr,
  output logic            exc_pending,
  output logic            exc_write,
  output logic [1:0]      exc_code,
  output logic [VA_W-1:0] exc_vaddr,
  input  logic            exc_ack
);

  localparam int SUM_W = PA_W + 1;

  logic [PA_W-1:0]  base_q;
  logic [VA_W-1:0]  ceil_q;
  logic [SUM_W-1:0] sum;
  logic             over_ceil, over_phys, fault, capture;

  assign sum       = SUM_W'(base_q) + SUM_W'(req_vaddr);
  assign over_ceil = req_vaddr > ceil_q;
  assign over_phys = sum[PA_W];
  assign fault     = req_valid && (over_ceil || over_phys);
  assign capture   = fault && (!exc_pending || exc_ack);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ceil_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) ceil_q <= cfg_data[VA_W-1:0];
      else         base_q <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_write <= 1'b0;
      mem_paddr <= '0;
    end else begin
      mem_valid <= req_valid && !fault;
      if (req_valid && !fault) begin
        mem_write <= req_write;
        mem_paddr <= sum[PA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_pending <= 1'b0;
      exc_write   <= 1'b0;
      exc_code    <= '0;
      exc_vaddr   <= '0;
    end else begin
      if (exc_ack) exc_pending <= 1'b0;
      if (fault)   exc_pending <= 1'b1;
      if (capture) begin
        exc_write <= req_write;
        exc_code  <= {over_phys, over_ceil};
        exc_vaddr <= req_vaddr;
      end
    end
  end

  p_paddr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !over_ceil && !over_phys |=>
      mem_valid && (mem_paddr - $past(base_q)) == PA_W'($past(req_vaddr)));

  p_ceiling_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_vaddr > ceil_q |=> !mem_valid && exc_pending);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !$past(over_phys));

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !mem_valid);

  p_cfg_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_sel |=> base_q == $past(cfg_data));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pending && !exc_ack |=> exc_pending && $stable(exc_vaddr) && $stable(exc_code)
      && $stable(exc_write));

endmodule

// File: tb/reloc_limit_unit_test.sv
`timescale 1ns/1ps
module reloc_limit_unit_test;
  localparam int VA_W = 4;
  localparam int PA_W = 5;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [PA_W-1:0] cfg_data = '0;
  logic req_valid = 0, req_write = 0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic mem_valid, mem_write, exc_pending, exc_write, exc_ack = 0;
  logic [PA_W-1:0] mem_paddr;
  logic [1:0] exc_code;
  logic [VA_W-1:0] exc_vaddr;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  reloc_limit_unit #(.VA_W(VA_W), .PA_W(PA_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_paddr(mem_paddr),
    .exc_pending(exc_pending), .exc_write(exc_write), .exc_code(exc_code),
    .exc_vaddr(exc_vaddr), .exc_ack(exc_ack));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic sel, input int val);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_data = PA_W'(val);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic request(input int va, input logic wr, input logic ack);
    @(negedge clk);
    req_valid = 1; req_vaddr = VA_W'(va); req_write = wr; exc_ack = ack;
    @(negedge clk);
    req_valid = 0; exc_ack = 0;
  endtask

  task automatic ack_pulse();
    exc_ack = 1;
    @(negedge clk);
    exc_ack = 0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R8 mem_valid after reset", int'(mem_valid), 0);
    check("R8 exc_pending after reset", int'(exc_pending), 0);
    request(0, 0, 0);
    check("R8 base 0 gives valid", int'(mem_valid), 1);
    check("R8 base 0 paddr", int'(mem_paddr), 0);
    request(1, 0, 0);
    check("R8 ceiling 0 faults at 1", int'(exc_pending), 1);
    check("R8 no access on fault", int'(mem_valid), 0);
    ack_pulse();

    for (int b = 0; b < 32; b++) begin
      cfg(0, b);
      for (int l = 0; l < 16; l++) begin
        cfg(1, l);
        for (int v = 0; v < 16; v++) begin
          logic wr;
          int code;
          wr = logic'((v + b) % 2);
          code = ((v > l) ? 1 : 0) + ((b + v > 31) ? 2 : 0);
          request(v, wr, 0);
          if (code == 0) begin
            check("R1 R4 mem_valid", int'(mem_valid), 1);
            check("R1 paddr", int'(mem_paddr), b + v);
            check("R1 write flag", int'(mem_write), int'(wr));
          end else begin
            check("R5 no access on fault", int'(mem_valid), 0);
            check("R5 exc_pending", int'(exc_pending), 1);
            check("R2 R3 exc_code", int'(exc_code), code);
            check("R7 exc_vaddr", int'(exc_vaddr), v);
            check("R7 exc_write", int'(exc_write), int'(wr));
            ack_pulse();
            check("R7 ack clears", int'(exc_pending), 0);
          end
        end
      end
    end

    @(negedge clk);
    check("R4 idle gives no access", int'(mem_valid), 0);

    cfg(0, 3); cfg(1, 15);
    @(negedge clk);
    req_valid = 1; req_vaddr = 2; req_write = 0;
    cfg_we = 1; cfg_sel = 0; cfg_data = 10;
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    check("R6 same-cycle write uses old base", int'(mem_paddr), 5);
    request(2, 0, 0);
    check("R6 new base on next request", int'(mem_paddr), 12);
    @(negedge clk);
    req_valid = 1; req_vaddr = 9;
    cfg_we = 1; cfg_sel = 1; cfg_data = 4;
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    check("R6 same-cycle ceiling write not yet applied", int'(mem_valid), 1);

    cfg(0, 0);
    request(9, 1, 0);
    check("R7 first fault vaddr", int'(exc_vaddr), 9);
    request(7, 0, 0);
    check("R7 later fault keeps vaddr", int'(exc_vaddr), 9);
    check("R7 later fault keeps write", int'(exc_write), 1);
    request(6, 0, 1);
    check("R7 fault with ack captured", int'(exc_vaddr), 6);
    check("R7 still pending", int'(exc_pending), 1);
    ack_pulse();
    check("R7 cleared", int'(exc_pending), 0);
    request(4, 0, 0);
    check("R2 equal to ceiling passes", int'(mem_valid), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule